// File: doc/BRIEF.md
# Chunked Packet Header Parser

This block takes a packet as a stream of 8-byte chunks and walks a small protocol graph. An Ethernet header comes first. It may be followed by one 802.1Q tag. An IPv4 header can follow either of those. The block decides which headers the packet carries and copies the interesting fields into one fixed-layout header vector. That vector also holds a presence bit for each header, a truncation bit and the packet's total byte count.

Chunks arrive on a valid/ready stream that carries start- and end-of-packet markers and a byte count for the last chunk. Field bytes are captured lane by lane at absolute packet offsets, so a field that straddles two chunks is assembled without special handling. The EtherType codes that drive the graph transitions are parameters, and the header offsets sit in a shared package.

One header vector is produced per packet, after the last chunk has been accepted. It is held on a valid/ready output until it is taken, and input is stalled while it waits.

Top module: `np_hdr_parser`

## Requirements
- R1: Chunk `in_data` carries packet byte offset 8k+i of chunk k in bits [63-8i -: 8]. On the chunk marked end-of-packet, `in_bytes` (1..8) counts the valid bytes starting from lane 0, and the remaining lanes are ignored. A field that crosses a chunk boundary is extracted whole.
- R2: The vector `phv` has a fixed layout. Bits [127:112] hold the length, [111:96] the EtherType, [95:84] the VLAN ID, [83:52] the IPv4 source, [51:20] the IPv4 destination, [19:12] the IPv4 protocol and [11:4] the TTL. Bit 3 is Ethernet-present, bit 2 VLAN-present, bit 1 IPv4-present and bit 0 truncation. Any field slot whose header is not present reads zero.
- R3: An outer EtherType (bytes 12..13) of 0x8100 selects the VLAN state. A complete tag (bytes 14..17) sets bit 2. The VLAN ID is the low 12 bits of bytes 14..15, and the EtherType slot takes the inner type from bytes 16..17.
- R4: The IPv4 state is entered on type 0x0800, either from the outer type or from the inner type after a complete tag. The header starts at offset 14, or at 18 when a tag is present. TTL sits at +8, protocol at +9, source at +12..15 and destination at +16..19. When all 20 bytes are present, bit 1 is set and these fields are extracted.
- R5: Any other type ends the walk with no error. The EtherType slot shows that type, and only the headers already completed are flagged.
- R6: The length slot equals the total number of bytes accepted for the packet.
- R7: A packet that ends inside a header leaves that header's bit clear and sets bit 0. This applies to fewer than 14 bytes, to a tag cut short, and to an IPv4 header cut short. A packet that ends exactly on a header boundary is not truncated.
- R8: Exactly one vector is produced per packet. `phv_valid` rises in the cycle after the end-of-packet chunk is accepted.
- R9: While `phv_valid` is high and `phv_ready` is low, `phv` holds steady and `in_ready` stays low.
- R10: A chunk accepted outside a packet without a start marker is ignored. A start marker in the middle of a packet abandons the old packet and restarts parsing.
- R11: After reset, `phv_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Chunk valid |
| in_ready | output | 1 | Chunk accepted when high with in_valid |
| in_data | input | 64 | Chunk bytes, lowest offset in the top byte |
| in_sop | input | 1 | First chunk of a packet |
| in_eop | input | 1 | Last chunk of a packet |
| in_bytes | input | 4 | Valid bytes in the last chunk |
| phv_valid | output | 1 | Header vector valid |
| phv_ready | input | 1 | Header vector taken when high with phv_valid |
| phv | output | 128 | Header vector |

## Verification
The bench aims at the header boundaries. It runs packets that stop one byte short of an IPv4 header, and packets that stop exactly at its end or exactly after the Ethernet header. A wrong comparison there would flip a presence bit or raise a false truncation. Fields that cross chunks, such as an IPv4 destination split over two chunks, would come out with a stale or garbage byte if lanes were matched per chunk instead of per packet offset. Garbage placed beyond `in_bytes` would leak into the last field if the lane mask were missing. The tests also cover back-pressure, stray chunks and a mid-packet restart. A design that overwrote a pending vector, emitted output for orphan chunks or kept fields from an abandoned packet would show up there.

// File: rtl/np_parse_pkg.sv
package np_parse_pkg;

    localparam int LEN_W = 16;
    localparam int PHV_W = 128;

    // header geometry in bytes
    localparam int ETH_LEN      = 14;
    localparam int OFF_ETYPE    = 12;
    localparam int VLAN_LEN     = 4;
    localparam int OFF_TCI      = 14;
    localparam int OFF_INNER_ET = 16;
    localparam int IP_LEN       = 20;
    localparam int IP_OFF_TTL   = 8;
    localparam int IP_OFF_PROTO = 9;
    localparam int IP_OFF_SRC   = 12;
    localparam int IP_OFF_DST   = 16;

    typedef struct packed {
        logic [15:0] et_outer;
        logic [15:0] tci;
        logic [15:0] et_inner;
        logic [7:0]  ttl;
        logic [7:0]  proto;
        logic [31:0] src;
        logic [31:0] dst;
    } hdr_fields_t;

    typedef struct packed {
        logic             in_pkt;
        logic [LEN_W-1:0] pos;
        hdr_fields_t      f;
        logic             out_valid;
        logic [PHV_W-1:0] phv;
    } parse_state_t;

endpackage

// File: rtl/np_field_grab.sv
module np_field_grab #(
    parameter int CHUNK_BYTES = 8,
    parameter int FIELD_BYTES = 2,
    parameter int POS_W       = 16,
    localparam int DATA_W     = CHUNK_BYTES * 8,
    localparam int FW         = FIELD_BYTES * 8
) (
    input  logic [POS_W-1:0]       chunk_pos,
    input  logic [POS_W-1:0]       field_off,
    input  logic [DATA_W-1:0]      chunk_data,
    input  logic [CHUNK_BYTES-1:0] lane_en,
    input  logic [FW-1:0]          held,
    output logic [FW-1:0]          merged
);

    for (genvar b = 0; b < FIELD_BYTES; b++) begin : g_byte
        logic [7:0]     byte_v;
        logic [POS_W:0] want;
        assign want = {1'b0, field_off} + (POS_W+1)'(b);
        always_comb begin
            byte_v = held[(FIELD_BYTES-1-b)*8 +: 8];
            for (int l = 0; l < CHUNK_BYTES; l++) begin
                if (lane_en[l] && (({1'b0, chunk_pos} + (POS_W+1)'(l)) == want)) begin
                    byte_v = chunk_data[(CHUNK_BYTES-1-l)*8 +: 8];
                end
            end
        end
        assign merged[(FIELD_BYTES-1-b)*8 +: 8] = byte_v;
    end

endmodule

// File: rtl/np_parse_verdict.sv
module np_parse_verdict
    import np_parse_pkg::*;
#(
    parameter logic [15:0] ETYPE_VLAN = 16'h8100,
    parameter logic [15:0] ETYPE_IPV4 = 16'h0800
) (
    input  hdr_fields_t      f,
    input  logic [LEN_W-1:0] pkt_len,
    output logic [PHV_W-1:0] phv
);

    logic             eth_ok, is_vlan, vlan_ok, ip_try, ip_ok, trunc;
    logic [LEN_W-1:0] ip_end;
    logic [15:0]      et_slot;
    logic [11:0]      vid_slot;
    logic             unused_pcp;

    assign unused_pcp = ^f.tci[15:12];

    always_comb begin
        eth_ok  = pkt_len >= LEN_W'(ETH_LEN);
        is_vlan = eth_ok && (f.et_outer == ETYPE_VLAN);
        vlan_ok = is_vlan && (pkt_len >= LEN_W'(ETH_LEN + VLAN_LEN));
        ip_try  = (eth_ok && !is_vlan && (f.et_outer == ETYPE_IPV4)) ||
                  (vlan_ok && (f.et_inner == ETYPE_IPV4));
        ip_end  = is_vlan ? LEN_W'(ETH_LEN + VLAN_LEN + IP_LEN) : LEN_W'(ETH_LEN + IP_LEN);
        ip_ok   = ip_try && (pkt_len >= ip_end);
        trunc   = !eth_ok || (is_vlan && !vlan_ok) || (ip_try && !ip_ok);

        if (vlan_ok)                et_slot = f.et_inner;
        else if (eth_ok && !is_vlan) et_slot = f.et_outer;
        else                        et_slot = '0;
        vid_slot = vlan_ok ? f.tci[11:0] : '0;

        phv = {pkt_len, et_slot, vid_slot,
               ip_ok ? f.src   : 32'd0,
               ip_ok ? f.dst   : 32'd0,
               ip_ok ? f.proto : 8'd0,
               ip_ok ? f.ttl   : 8'd0,
               eth_ok, vlan_ok, ip_ok, trunc};
    end

endmodule

// File: rtl/np_hdr_parser.sv
module np_hdr_parser
    import np_parse_pkg::*;
#(
    parameter int          CHUNK_BYTES = 8,
    parameter logic [15:0] ETYPE_VLAN  = 16'h8100,
    parameter logic [15:0] ETYPE_IPV4  = 16'h0800,
    localparam int DATA_W = CHUNK_BYTES * 8,
    localparam int CNT_W  = $clog2(CHUNK_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [CNT_W-1:0]  in_bytes,
    output logic              phv_valid,
    input  logic              phv_ready,
    output logic [PHV_W-1:0]  phv
);

    parse_state_t q, d;
    hdr_fields_t  held_f, merged_f;

    logic                   accept, take;
    logic [CHUNK_BYTES-1:0] lane_en;
    logic [LEN_W-1:0]       chunk_pos, ip_base, pos_sum;
    logic [LEN_W:0]         pos_wide;
    logic [CNT_W-1:0]       chunk_cnt;
    logic [PHV_W-1:0]       phv_new;

    assign in_ready  = !q.out_valid || phv_ready;
    assign accept    = in_valid && in_ready;
    assign take      = accept && (in_sop || q.in_pkt);
    assign chunk_pos = in_sop ? '0 : q.pos;
    assign held_f    = in_sop ? '0 : q.f;

    always_comb begin
        for (int l = 0; l < CHUNK_BYTES; l++) begin
            lane_en[l] = take && (!in_eop || (CNT_W'(l) < in_bytes));
        end
    end

    assign chunk_cnt = in_eop ? in_bytes : CNT_W'(CHUNK_BYTES);
    assign pos_wide  = {1'b0, chunk_pos} + (LEN_W+1)'(chunk_cnt);
    assign pos_sum   = pos_wide[LEN_W] ? '1 : pos_wide[LEN_W-1:0];

    // Ethernet and VLAN fields sit at fixed offsets
    np_field_grab #(.CHUNK_BYTES(CHUNK_BYTES), .FIELD_BYTES(2), .POS_W(LEN_W)) u_et_outer (
        .chunk_pos(chunk_pos), .field_off(LEN_W'(OFF_ETYPE)), .chunk_data(in_data),
        .lane_en(lane_en), .held(held_f.et_outer), .merged(merged_f.et_outer));

    np_field_grab #(.CHUNK_BYTES(CHUNK_BYTES), .FIELD_BYTES(2), .POS_W(LEN_W)) u_tci (
        .chunk_pos(chunk_pos), .field_off(LEN_W'(OFF_TCI)), .chunk_data(in_data),
        .lane_en(lane_en), .held(held_f.tci), .merged(merged_f.tci));

    np_field_grab #(.CHUNK_BYTES(CHUNK_BYTES), .FIELD_BYTES(2), .POS_W(LEN_W)) u_et_inner (
        .chunk_pos(chunk_pos), .field_off(LEN_W'(OFF_INNER_ET)), .chunk_data(in_data),
        .lane_en(lane_en), .held(held_f.et_inner), .merged(merged_f.et_inner));

    // IPv4 base follows the graph: shifted by a tag when one is present
    assign ip_base = (merged_f.et_outer == ETYPE_VLAN) ? LEN_W'(ETH_LEN + VLAN_LEN)
                                                       : LEN_W'(ETH_LEN);

    np_field_grab #(.CHUNK_BYTES(CHUNK_BYTES), .FIELD_BYTES(1), .POS_W(LEN_W)) u_ttl (
        .chunk_pos(chunk_pos), .field_off(ip_base + LEN_W'(IP_OFF_TTL)), .chunk_data(in_data),
        .lane_en(lane_en), .held(held_f.ttl), .merged(merged_f.ttl));

    np_field_grab #(.CHUNK_BYTES(CHUNK_BYTES), .FIELD_BYTES(1), .POS_W(LEN_W)) u_proto (
        .chunk_pos(chunk_pos), .field_off(ip_base + LEN_W'(IP_OFF_PROTO)), .chunk_data(in_data),
        .lane_en(lane_en), .held(held_f.proto), .merged(merged_f.proto));

    np_field_grab #(.CHUNK_BYTES(CHUNK_BYTES), .FIELD_BYTES(4), .POS_W(LEN_W)) u_src (
        .chunk_pos(chunk_pos), .field_off(ip_base + LEN_W'(IP_OFF_SRC)), .chunk_data(in_data),
        .lane_en(lane_en), .held(held_f.src), .merged(merged_f.src));

    np_field_grab #(.CHUNK_BYTES(CHUNK_BYTES), .FIELD_BYTES(4), .POS_W(LEN_W)) u_dst (
        .chunk_pos(chunk_pos), .field_off(ip_base + LEN_W'(IP_OFF_DST)), .chunk_data(in_data),
        .lane_en(lane_en), .held(held_f.dst), .merged(merged_f.dst));

    np_parse_verdict #(.ETYPE_VLAN(ETYPE_VLAN), .ETYPE_IPV4(ETYPE_IPV4)) u_verdict (
        .f(merged_f), .pkt_len(pos_sum), .phv(phv_new));

    always_comb begin
        d = q;
        if (q.out_valid && phv_ready) begin
            d.out_valid = 1'b0;
        end
        if (take) begin
            d.f      = merged_f;
            d.pos    = pos_sum;
            d.in_pkt = !in_eop;
            if (in_eop) begin
                d.out_valid = 1'b1;
                d.phv       = phv_new;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign phv_valid = q.out_valid;
    assign phv       = q.phv;

endmodule

// File: rtl/np_hdr_parser_chk.sv
module np_hdr_parser_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         in_ready,
    input logic         in_eop,
    input logic         phv_valid,
    input logic         phv_ready,
    input logic [127:0] phv
);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        phv_valid && !phv_ready |=> phv_valid && $stable(phv));

    p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        phv_valid && !phv_ready |-> !in_ready);

    p_rise_after_eop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phv_valid) |-> $past(in_valid && in_ready && in_eop));

    p_vlan_needs_eth_r3: assert property (@(posedge clk) disable iff (!rst_n)
        phv_valid && phv[2] |-> phv[3]);

    p_ip_needs_eth_r4: assert property (@(posedge clk) disable iff (!rst_n)
        phv_valid && phv[1] |-> phv[3] && !phv[0]);

    p_no_eth_trunc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        phv_valid && !phv[3] |-> phv[0]);

endmodule

bind np_hdr_parser np_hdr_parser_chk chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_eop(in_eop), .phv_valid(phv_valid), .phv_ready(phv_ready), .phv(phv));

// File: tb/np_hdr_parser_tb_top.sv
`timescale 1ns/1ps
module np_hdr_parser_tb_top;

    typedef struct packed {
        logic        vlan;
        logic [15:0] et;
        logic [15:0] inner;
        logic [11:0] vid;
        logic [31:0] src;
        logic [31:0] dst;
        logic [7:0]  ttl;
        logic [7:0]  proto;
        logic [15:0] len;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'h0800, 16'h0000, 12'h000, 32'hC0A80101, 32'h0A000002, 8'd64,  8'd6,  16'd60},
        '{1'b1, 16'h0000, 16'h0800, 12'hABC, 32'h01020304, 32'hF0E0D0C0, 8'd17,  8'd17, 16'd64},
        '{1'b0, 16'h86DD, 16'h0000, 12'h000, 32'h11111111, 32'h22222222, 8'd1,   8'd1,  16'd40},
        '{1'b1, 16'h0000, 16'h0806, 12'h123, 32'h0,        32'h0,        8'd0,   8'd0,  16'd30},
        '{1'b0, 16'h0800, 16'h0000, 12'h000, 32'hAAAAAAAA, 32'hBBBBBBBB, 8'd9,   8'd9,  16'd20},
        '{1'b0, 16'h0800, 16'h0000, 12'h000, 32'h0,        32'h0,        8'd0,   8'd0,  16'd10},
        '{1'b1, 16'h0000, 16'h0800, 12'h555, 32'h0,        32'h0,        8'd0,   8'd0,  16'd16},
        '{1'b1, 16'h0000, 16'h0800, 12'hFFF, 32'hDEADBEEF, 32'h12345678, 8'd255, 8'd1,  16'd38},
        '{1'b0, 16'h0800, 16'h0000, 12'h000, 32'h0A0B0C0D, 32'h01020304, 8'd5,   8'd50, 16'd33},
        '{1'b0, 16'h1234, 16'h0000, 12'h000, 32'h0,        32'h0,        8'd0,   8'd0,  16'd14}
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic         in_ready;
    logic [63:0]  in_data;
    logic         in_sop;
    logic         in_eop;
    logic [3:0]   in_bytes;
    logic         phv_valid;
    logic         phv_ready;
    logic [127:0] phv;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 0;
    logic [7:0] pkt [0:127];

    always #2.5 clk = ~clk;

    np_hdr_parser dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .in_bytes(in_bytes),
        .phv_valid(phv_valid), .phv_ready(phv_ready), .phv(phv));

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    function automatic logic [127:0] expect_phv(vec_t v);
        logic [15:0] outer;
        logic eth, isv, vok, ipt, iok, tr;
        int base;
        logic [15:0] ets;
        outer = v.vlan ? 16'h8100 : v.et;
        eth   = v.len >= 14;
        isv   = eth && outer == 16'h8100;
        vok   = isv && v.len >= 18;
        ipt   = (eth && !isv && outer == 16'h0800) || (vok && v.inner == 16'h0800);
        base  = isv ? 18 : 14;
        iok   = ipt && (int'(v.len) >= base + 20);
        tr    = !eth || (isv && !vok) || (ipt && !iok);
        ets   = vok ? v.inner : ((eth && !isv) ? outer : 16'h0);
        return {v.len, ets, vok ? v.vid : 12'h0,
                iok ? v.src : 32'h0, iok ? v.dst : 32'h0,
                iok ? v.proto : 8'h0, iok ? v.ttl : 8'h0,
                eth, vok, iok, tr};
    endfunction

    task automatic build(vec_t v);
        int base;
        for (int i = 0; i < 128; i++) pkt[i] = 8'h40 + 8'(i);
        {pkt[12], pkt[13]} = v.vlan ? 16'h8100 : v.et;
        base = 14;
        if (v.vlan) begin
            {pkt[14], pkt[15]} = {4'hA, v.vid};
            {pkt[16], pkt[17]} = v.inner;
            base = 18;
        end
        pkt[base+8] = v.ttl;
        pkt[base+9] = v.proto;
        {pkt[base+12], pkt[base+13], pkt[base+14], pkt[base+15]} = v.src;
        {pkt[base+16], pkt[base+17], pkt[base+18], pkt[base+19]} = v.dst;
    endtask

    // sends bytes [0, len) of pkt; with_eop=0 leaves the packet open
    task automatic send(input int len, input bit with_eop);
        int nch;
        nch = (len + 7) / 8;
        for (int c = 0; c < nch; c++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sop   = (c == 0);
            in_eop   = with_eop && (c == nch - 1);
            in_bytes = (c == nch - 1) ? 4'(len - c*8) : 4'd8;
            for (int l = 0; l < 8; l++) begin
                in_data[(7-l)*8 +: 8] = (c*8 + l < len) ? pkt[c*8 + l] : 8'hEE;
            end
            while (!in_ready) @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sop   = 1'b0;
        in_eop   = 1'b0;
    endtask

    function automatic string tag_of(int i);
        case (i)
            0: return "R4 R1 plain IPv4";
            1: return "R3 R4 R1 tagged IPv4";
            2: return "R5 other type";
            3: return "R3 R5 tagged other";
            4: return "R7 IPv4 cut";
            5: return "R7 short Ethernet";
            6: return "R7 tag cut";
            7: return "R4 exact IPv4 end";
            8: return "R7 R1 one byte short, lane mask";
            default: return "R5 exact Ethernet end";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic [127:0] e;
        logic [127:0] held;
        rst_n = 1'b0; in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        in_bytes = 4'd0; in_data = '0; phv_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(phv_valid == 1'b0, "R11 reset phv_valid", 128'(phv_valid), 128'd0);
        check(in_ready == 1'b1, "R11 reset in_ready", 128'(in_ready), 128'd1);

        // vector table
        for (int i = 0; i < NV; i++) begin
            build(VECS[i]);
            e = expect_phv(VECS[i]);
            send(int'(VECS[i].len), 1'b1);
            check(phv_valid == 1'b1, "R8 valid after eop", 128'(phv_valid), 128'd1);
            check(phv[127:112] == e[127:112], "R6 length slot", 128'(phv[127:112]), 128'(e[127:112]));
            check(phv == e, {"R2 ", tag_of(i)}, phv, e);
            @(negedge clk);
            check(phv_valid == 1'b0, "R8 single vector", 128'(phv_valid), 128'd0);
        end

        // back-pressure
        phv_ready = 1'b0;
        build(VECS[0]);
        e = expect_phv(VECS[0]);
        send(int'(VECS[0].len), 1'b1);
        held = phv;
        in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b1; in_bytes = 4'd8;
        repeat (3) begin
            @(negedge clk);
            check(in_ready == 1'b0, "R9 stall in_ready", 128'(in_ready), 128'd0);
            check(phv_valid && phv == e, "R9 hold vector", phv, e);
        end
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        check(phv == held, "R9 stable", phv, held);
        phv_ready = 1'b1;
        @(negedge clk);
        check(phv_valid == 1'b0, "R9 drained", 128'(phv_valid), 128'd0);

        // stray chunk outside a packet
        @(negedge clk);
        in_valid = 1'b1; in_sop = 1'b0; in_eop = 1'b1; in_bytes = 4'd8; in_data = 64'hFFFF_FFFF_FFFF_FFFF;
        @(negedge clk);
        in_valid = 1'b0; in_eop = 1'b0;
        repeat (2) begin
            check(phv_valid == 1'b0, "R10 stray chunk ignored", 128'(phv_valid), 128'd0);
            @(negedge clk);
        end

        // abandoned packet then restart
        build(VECS[7]);
        send(24, 1'b0);
        build(VECS[1]);
        e = expect_phv(VECS[1]);
        send(int'(VECS[1].len), 1'b1);
        check(phv_valid && phv == e, "R10 restart on sop", phv, e);
        @(negedge clk);

        // stray chunk after a packet must not disturb the next one
        in_valid = 1'b1; in_sop = 1'b0; in_eop = 1'b0; in_bytes = 4'd8; in_data = 64'h0800_0800_0800_0800;
        @(negedge clk);
        in_valid = 1'b0;
        build(VECS[2]);
        e = expect_phv(VECS[2]);
        send(int'(VECS[2].len), 1'b1);
        check(phv_valid && phv == e, "R10 after stray", phv, e);
        @(negedge clk);

        finish_up();
    end

endmodule